// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking translation tables in memory. A request carries a logical address and the table base of the current address space. The walker fetches a first-level descriptor, selected by the top twelve address bits. That descriptor may map a 1 MiB section directly. It may instead point at a second-level table, whose descriptor, selected by the next eight address bits, maps either a 64 KiB large page or a 4 KiB small page.

The result is the descriptor's base bits joined to the untranslated low bits of the logical address. Descriptors whose type field is not a valid mapping end the walk with a fault. The walker issues one descriptor read per level over a valid/ready read port whose data returns in the handshake cycle. It reports each result with a one-cycle completion pulse. It accepts one request at a time.

Top module: `xlat_walker`

## Requirements
- R1: During and directly after reset, `req_ready_o` is high, and `mem_valid_o` and `done_o` are low.
- R2: The first read after a request is accepted is at address `{ttb_i[31:14], vaddr[31:20], 2'b00}`, with both values taken at acceptance. Table-base bits 13:0 are ignored.
- R3: A first-level descriptor with bits 1:0 = `10` is a section. The result is `{desc[31:20], vaddr[19:0]}`, no fault, and there is no second read.
- R4: A first-level descriptor with bits 1:0 = `01` is a table pointer. The second read is at `{desc[31:10], vaddr[19:12], 2'b00}`, and descriptor bits 9:2 are ignored.
- R5: A second-level descriptor with bits 1:0 = `01` is a large page. The result is `{desc[31:16], vaddr[15:0]}`, no fault.
- R6: A second-level descriptor with bits 1:0 = `10` is a small page. The result is `{desc[31:12], vaddr[11:0]}`, no fault.
- R7: A descriptor with bits 1:0 equal to `00` or `11` at either level ends the walk with `fault_o` high and `paddr_o` zero. No further read follows it.
- R8: While `mem_valid_o` is high and `mem_ready_i` is low, the read request stays up with an unchanged address. The walker makes exactly one read per level visited.
- R9: `req_ready_o` is high only while idle. Requests and changes on `req_vaddr_i` or `ttb_i` during a walk have no effect. `done_o` is a single-cycle pulse.
- R10: `done_o` rises in the cycle after the last descriptor handshake. With `mem_ready_i` held high, this is 2 cycles after acceptance for a one-level walk and 3 cycles for a two-level walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_vaddr_i | input | 32 | Logical address to translate |
| ttb_i | input | 32 | Translation table base, bits 31:14 used |
| mem_valid_o | output | 1 | Descriptor read request |
| mem_ready_i | input | 1 | Read completes, data valid this cycle |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_rdata_i | input | 32 | Descriptor returned on handshake |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended on an invalid descriptor, valid with done_o |
| paddr_o | output | 32 | Physical address, valid with done_o |

## Verification
Every cycle, the assertions check several properties. The read request must hold steady under back-pressure. The first-level address must follow from the accepted request. Completion must come only straight after a handshake, and must be a single pulse. Faults must return a zero address, and idle must exclude both reading and completing. Which descriptor type leads to which address concatenation can only be seen in the scenarios. The same holds for the second-level read address, the ignored descriptor bits and the cycle counts. Those scenarios sweep every first-level index and every second-level index of selected tables, under random stalls, against a descriptor model computed in the bench.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2, ST_DONE} walk_st_e;
  typedef enum logic [2:0] {DK_FAULT, DK_TABLE, DK_SECTION, DK_LARGE, DK_SMALL} desc_kind_e;
  localparam logic [1:0] TYPE_LINK = 2'b01;  // L1 table pointer / L2 large page
  localparam logic [1:0] TYPE_MAP  = 2'b10;  // L1 section / L2 small page
endpackage

// File: rtl/xlat_desc_decode.sv
`timescale 1ns/1ps
module xlat_desc_decode
  import xlat_pkg::*;
#(
  parameter int DESC_W = 32
) (
  input  logic              second_lvl_i,
  input  logic [DESC_W-1:0] desc_i,
  output desc_kind_e        kind_o
);
  always_comb begin
    unique case (desc_i[1:0])
      TYPE_LINK: kind_o = second_lvl_i ? DK_LARGE : DK_TABLE;
      TYPE_MAP:  kind_o = second_lvl_i ? DK_SMALL : DK_SECTION;
      default:   kind_o = DK_FAULT;
    endcase
  end
endmodule

// File: rtl/xlat_pa_form.sv
`timescale 1ns/1ps
module xlat_pa_form
  import xlat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SECT_OFF_W  = 20,
  parameter int LARGE_OFF_W = 16,
  parameter int SMALL_OFF_W = 12
) (
  input  desc_kind_e        kind_i,
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [ADDR_W-1:0] paddr_o
);
  localparam int NUM_GRAN = 3;
  localparam int OFF_W [NUM_GRAN] = '{SECT_OFF_W, LARGE_OFF_W, SMALL_OFF_W};

  logic [ADDR_W-1:0] gran_pa [NUM_GRAN];

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
    localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << OFF_W[g]) - ADDR_W'(1);
    assign gran_pa[g] = (desc_i & ~OFF_MASK) | (vaddr_i & OFF_MASK);
  end

  always_comb begin
    unique case (kind_i)
      DK_SECTION: paddr_o = gran_pa[0];
      DK_LARGE:   paddr_o = gran_pa[1];
      DK_SMALL:   paddr_o = gran_pa[2];
      default:    paddr_o = '0;
    endcase
  end
endmodule

// File: rtl/xlat_walk_ctrl.sv
`timescale 1ns/1ps
module xlat_walk_ctrl
  import xlat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       mem_ready_i,
  input  desc_kind_e kind_i,
  output walk_st_e   state_o,
  output logic       req_ready_o,
  output logic       mem_valid_o,
  output logic       done_o
);
  walk_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_L1;
      ST_L1:   if (mem_ready_i) state_d = (kind_i == DK_TABLE) ? ST_L2 : ST_DONE;
      ST_L2:   if (mem_ready_i) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_L1) || (state_q == ST_L2);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SECT_OFF_W  = 20,
  parameter int LARGE_OFF_W = 16,
  parameter int SMALL_OFF_W = 12,
  parameter int DESC_LG     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [ADDR_W-1:0] ttb_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] paddr_o
);
  localparam int L1_IDX_W = ADDR_W - SECT_OFF_W;
  localparam int L2_IDX_W = SECT_OFF_W - SMALL_OFF_W;
  localparam int TTB_LSB  = L1_IDX_W + DESC_LG;
  localparam int L2B_LSB  = L2_IDX_W + DESC_LG;
  localparam logic [ADDR_W-1:0] TTB_LO  = (ADDR_W'(1) << TTB_LSB) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] L2B_LO  = (ADDR_W'(1) << L2B_LSB) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX2_MK = (ADDR_W'(1) << L2_IDX_W) - ADDR_W'(1);

  walk_st_e          state;
  desc_kind_e        kind;
  logic [ADDR_W-1:0] vaddr_q, ttb_q, l2_desc_q, pa_q, pa_w;
  logic              fault_q;
  logic              req_fire, mem_fire;

  xlat_walk_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mem_ready_i (mem_ready_i),
    .kind_i      (kind),
    .state_o     (state),
    .req_ready_o (req_ready_o),
    .mem_valid_o (mem_valid_o),
    .done_o      (done_o)
  );

  xlat_desc_decode #(.DESC_W(ADDR_W)) u_dec (
    .second_lvl_i (state == ST_L2),
    .desc_i       (mem_rdata_i),
    .kind_o       (kind)
  );

  xlat_pa_form #(
    .ADDR_W      (ADDR_W),
    .SECT_OFF_W  (SECT_OFF_W),
    .LARGE_OFF_W (LARGE_OFF_W),
    .SMALL_OFF_W (SMALL_OFF_W)
  ) u_pa (
    .kind_i  (kind),
    .desc_i  (mem_rdata_i),
    .vaddr_i (vaddr_q),
    .paddr_o (pa_w)
  );

  assign req_fire = req_valid_i && req_ready_o;
  assign mem_fire = mem_valid_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q   <= '0;
      ttb_q     <= '0;
      l2_desc_q <= '0;
      pa_q      <= '0;
      fault_q   <= 1'b0;
    end else begin
      if (req_fire) begin
        vaddr_q <= req_vaddr_i;
        ttb_q   <= ttb_i;
      end
      if (mem_fire) begin
        if (kind == DK_TABLE) begin
          l2_desc_q <= mem_rdata_i;
        end else begin
          pa_q    <= pa_w;
          fault_q <= (kind == DK_FAULT);
        end
      end
    end
  end

  always_comb begin
    if (state == ST_L2)
      mem_addr_o = (l2_desc_q & ~L2B_LO) |
                   (((vaddr_q >> SMALL_OFF_W) & IDX2_MK) << DESC_LG);
    else
      mem_addr_o = (ttb_q & ~TTB_LO) | ((vaddr_q >> SECT_OFF_W) << DESC_LG);
  end

  assign paddr_o = pa_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/xlat_walker_chk.sv
`timescale 1ns/1ps
module xlat_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int SECT_OFF_W = 20,
  parameter int DESC_LG    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic [ADDR_W-1:0] ttb_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [ADDR_W-1:0] paddr_o
);
  localparam int TTB_LSB = ADDR_W - SECT_OFF_W + DESC_LG;

  assert_l1_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_valid_o && mem_addr_o ==
      {$past(ttb_i[ADDR_W-1:TTB_LSB]), $past(req_vaddr_i[ADDR_W-1:SECT_OFF_W]), DESC_LG'(0)}));

  assert_fault_zero_pa_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (paddr_o == '0));

  assert_read_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_valid_o && !done_o));

  assert_done_after_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_valid_o && mem_ready_i));
endmodule

bind xlat_walker xlat_walker_chk #(
  .ADDR_W     (ADDR_W),
  .SECT_OFF_W (SECT_OFF_W),
  .DESC_LG    (DESC_LG)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_vaddr_i (req_vaddr_i),
  .ttb_i       (ttb_i),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .paddr_o     (paddr_o)
);

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;
  localparam logic [31:0] TTB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] ttb = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        done, fault;
  logic [31:0] paddr;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  xlat_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .ttb_i(ttb),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .paddr_o(paddr)
  );

  // Descriptor model: L1 table at TTB, L2 table for index i at 0x4000_0000 + i*1024
  function automatic logic [31:0] l1_desc(int i);
    logic [31:0] d;
    case (i % 4)
      0: d = {12'(i * 5), 20'h0} | 32'h0000_0F00;
      1: d = 32'h4000_0000 | (32'(i) << 10) | ((32'(i) & 32'hFF) << 2) | 32'h1;
      2: d = {12'((i * 7 + 5) & 12'hFFF), 18'((i * 13) & 18'h3FFFF), 2'b10};
      default: d = {12'(i), 18'h2AAAA, 2'b11};
    endcase
    return d;
  endfunction

  function automatic logic [31:0] l2_desc(int i, int j);
    logic [31:0] d;
    case (j % 4)
      0: d = {16'(i * 3 + j), 16'h0};
      1: d = {16'(i * 3 + j), 14'(j * 21), 2'b01};
      2: d = {20'(i * 11 + j * 5), 10'(i + j), 2'b10};
      default: d = {20'(j), 10'h155, 2'b11};
    endcase
    return d;
  endfunction

  always_comb begin
    if (mem_addr[31:30] == 2'b01) mem_rdata = l2_desc(int'(mem_addr[21:10]), int'(mem_addr[9:2]));
    else                          mem_rdata = l1_desc(int'(mem_addr[13:2]));
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic translate(input logic [31:0] va, input logic [31:0] ttb_in, input bit stall);
    int i, j, t1, iter, nreads;
    logic [31:0] d1, d2, e_a0, e_a1, e_pa, a0, a1;
    logic e_fault;
    int e_reads;
    bit seen;
    i = int'(va[31:20]); j = int'(va[19:12]);
    d1 = l1_desc(i); t1 = i % 4;
    e_a0 = {TTB[31:14], va[31:20], 2'b00};
    e_a1 = '0; e_fault = 1'b0; e_reads = 1;
    if (t1 == 2) e_pa = {d1[31:20], va[19:0]};
    else if (t1 == 1) begin
      e_reads = 2;
      e_a1 = {d1[31:10], va[19:12], 2'b00};
      d2 = l2_desc(i, j);
      case (j % 4)
        1: e_pa = {d2[31:16], va[15:0]};
        2: e_pa = {d2[31:12], va[11:0]};
        default: begin e_pa = '0; e_fault = 1'b1; end
      endcase
    end else begin e_pa = '0; e_fault = 1'b1; end

    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R9 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; ttb = ttb_in; mem_ready = 1'b0;
    @(negedge clk);
    // keep poking with other values: must be ignored (R9)
    req_vaddr = ~va; ttb = 32'hFFFF_C000 ^ ttb_in;
    iter = 1; nreads = 0; seen = 0; a0 = '0; a1 = '0;
    while (!seen && iter < 100) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (done) seen = 1;
      else begin
        if (mem_valid && mem_ready) begin
          if (nreads == 0) a0 = mem_addr; else a1 = mem_addr;
          nreads++;
        end
        @(negedge clk);
        iter++;
      end
    end
    chk(seen, "R10 walk completes", 32'(iter), 32'd3);
    chk(nreads == e_reads, "R8 read count", 32'(nreads), 32'(e_reads));
    chk(a0 == e_a0, "R2 first read address", a0, e_a0);
    if (e_reads == 2) chk(a1 == e_a1, "R4 second read address", a1, e_a1);
    chk(fault == e_fault, e_fault ? "R7 fault flag" : "R3 R5 R6 fault flag", {31'd0, fault}, {31'd0, e_fault});
    chk(paddr == e_pa, e_fault ? "R7 zero address" : "R3 R5 R6 R9 physical address", paddr, e_pa);
    if (!stall) chk(iter == e_reads + 1, "R10 latency", 32'(iter), 32'(e_reads + 1));
    req_valid = 1'b0; mem_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R9 done single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #2;
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R1 reset state",
        {29'd0, req_ready, mem_valid, done}, 32'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R1 after reset",
        {29'd0, req_ready, mem_valid, done}, 32'h4);
    // every first-level index, varied second-level index and offset
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] va;
      va = {12'(i), 8'((i * 37) & 255), 12'((i * 97 + 13) & 12'hFFF)};
      translate(va, (i % 2 == 1) ? (TTB | 32'h0000_3FFF) : TTB, ((i % 3) != 0));
    end
    // full second-level sweep of a few tables (R4 R5 R6 R7)
    for (int k = 0; k < 3; k++) begin
      int i;
      i = (k == 0) ? 1 : (k == 1) ? 2049 : 4093;
      for (int j = 0; j < 256; j++)
        translate({12'(i), 8'(j), 12'((j * 331) & 12'hFFF)}, TTB, (j % 2 == 1));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule